// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Thresholds

This block is a first-in first-out buffer for 9-bit words whose depth is a power of two from 256 to 8192 words. The write port runs on its own clock and the read port on another. The two clocks may be one and the same net, or they may be fully unrelated. Each port acts only when both of its enable inputs are high. This lets two upstream agents each veto a transfer without any gating logic outside the block.

Two hard flags report an empty or a full buffer. Two soft flags warn when the buffer is nearly drained or nearly filled, against thresholds that can be changed at run time. To program a threshold, raise the load input and write words through the normal write port. Each such write goes into the next slice of the threshold registers and is not stored as data. The read word comes from an output register. A separate output enable releases the read bus to high impedance.

Pointers cross between the clock domains as Gray code through two-stage synchronisers. The read-side flags are computed in the read domain and the write-side flags in the write domain. Thresholds should be changed only while the read side is idle, because the read side uses the almost-empty threshold without resynchronising it.

Top module: `sync9_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with all 9 bits intact. A read loads the oldest word into the output register on the read clock edge that accepts it.
- R2: A word is accepted on a rising write-clock edge only if `wr_en_a` and `wr_en_b` are both high. If either one is low, the buffer is unchanged.
- R3: A word is removed on a rising read-clock edge only if `rd_en_a` and `rd_en_b` are both high. If either one is low, the buffer and the output register are unchanged.
- R4: `empty` is high exactly when the occupancy is zero and `full` exactly when it equals DEPTH. A write attempted while `full` is high is dropped.
- R5: A read attempted while `empty` is high is dropped. The output register keeps its last value.
- R6: With the default thresholds, `almost_empty` is high when the occupancy is 7 or less, and `almost_full` is high when the occupancy is DEPTH-7 or more.
- R7: While `ofs_load` is high, each qualified write stores its 9-bit word into a threshold slice instead of the buffer. The slices fill in this order, then wrap to the first: almost-empty bits 8:0, almost-empty bits 17:9, almost-full bits 8:0, almost-full bits 17:9. `almost_empty` is high when occupancy <= the almost-empty value. `almost_full` is high when occupancy >= DEPTH minus the almost-full value.
- R8: When `out_en` is low, `rd_data` is released to high impedance. When it is high, `rd_data` shows the output register.
- R9: A low `rst_n` empties the buffer, sets `empty` and `almost_empty`, clears `full` and `almost_full`, restores both thresholds to 7, and returns the threshold load sequence to its first slice.
- R10: With independent, unrelated read and write clocks, all words arrive intact and in order, and each transferred pointer changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock (may be tied to wr_clk) |
| rst_n | input | 1 | Active-low reset for both sides |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| ofs_load | input | 1 | Routes qualified writes into the threshold registers |
| wr_data | input | 9 | Write word or threshold slice |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Drives rd_data when high, high impedance when low |
| rd_data | output | 9 | Read word |
| empty | output | 1 | Buffer holds no word (read domain) |
| full | output | 1 | Buffer holds DEPTH words (write domain) |
| almost_empty | output | 1 | Occupancy at or below the low threshold (read domain) |
| almost_full | output | 1 | Occupancy at or above the high threshold (write domain) |

## Verification
Assertions check several properties on every cycle. Writes against a full buffer, reads against an empty buffer and threshold-load writes must all leave the pointers untouched. A refused read must also leave the output register alone. Each Gray pointer may move by at most one bit, and a hard flag must always imply its matching soft flag. Other behaviour shows only through the bench's scenarios: the order of the data, where each soft flag switches under default and loaded thresholds, the order of the slices and the wrap after the fourth, the output-enable release, what reset restores, and whether the data survive with two unrelated clocks.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int DW    = 9;
    localparam int OFS_W = 2 * DW;
    localparam logic [OFS_W-1:0] OFS_DEFAULT = OFS_W'(7);

    typedef enum logic [1:0] {
        FLD_AE_LO = 2'd0,
        FLD_AE_HI = 2'd1,
        FLD_AF_LO = 2'd2,
        FLD_AF_HI = 2'd3
    } ofs_fld_e;
endpackage

// File: rtl/sfifo_sync2.sv
module sfifo_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/sfifo_ram.sv
module sfifo_ram
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sfifo_wr_ctl.sv
module sfifo_wr_ctl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int LW = OFS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             ld,
    input  logic [DW-1:0]    din,
    input  logic [PW-1:0]    rgray_s,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [PW-1:0]    wgray,
    output logic             full,
    output logic             almost_full,
    output logic [OFS_W-1:0] ae_ofs
);
    typedef struct packed {
        logic [PW-1:0]    ptr;
        logic [PW-1:0]    gray;
        logic [OFS_W-1:0] ae_ofs;
        logic [OFS_W-1:0] af_ofs;
        ofs_fld_e         fld;
    } wr_st_t;

    wr_st_t        st_d, st_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] level;
    logic [PW-1:0] ptr_inc;
    logic          req;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
        level       = st_q.ptr - rbin;
        full        = (level == PW'(DEPTH));
        almost_full = (LW'(level) + LW'(st_q.af_ofs)) >= LW'(DEPTH);
        req         = en_a & en_b;
        ptr_inc     = st_q.ptr + PW'(1);
        st_d        = st_q;
        we          = 1'b0;
        if (req && ld) begin
            unique case (st_q.fld)
                FLD_AE_LO: st_d.ae_ofs[DW-1:0]    = din;
                FLD_AE_HI: st_d.ae_ofs[OFS_W-1:DW] = din;
                FLD_AF_LO: st_d.af_ofs[DW-1:0]    = din;
                FLD_AF_HI: st_d.af_ofs[OFS_W-1:DW] = din;
            endcase
            st_d.fld = ofs_fld_e'(st_q.fld + 2'd1);
        end else if (req && !full) begin
            we        = 1'b1;
            st_d.ptr  = ptr_inc;
            st_d.gray = ptr_inc ^ (ptr_inc >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{ptr: '0, gray: '0, ae_ofs: OFS_DEFAULT,
                      af_ofs: OFS_DEFAULT, fld: FLD_AE_LO};
        else
            st_q <= st_d;
    end

    assign waddr  = st_q.ptr[AW-1:0];
    assign wgray  = st_q.gray;
    assign ae_ofs = st_q.ae_ofs;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && en_a && en_b) |=> $stable(st_q.ptr));
    // R7
    load_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && en_a && en_b) |=> $stable(st_q.ptr));
    // R10
    wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
    // R6
    full_implies_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);
endmodule

// File: rtl/sfifo_rd_ctl.sv
module sfifo_rd_ctl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int LW = OFS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_a,
    input  logic             en_b,
    input  logic [PW-1:0]    wgray_s,
    input  logic [DW-1:0]    rdata,
    input  logic [OFS_W-1:0] ae_ofs,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray,
    output logic             empty,
    output logic             almost_empty,
    output logic [DW-1:0]    dout
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [DW-1:0] dout;
    } rd_st_t;

    rd_st_t        st_d, st_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] level;
    logic [PW-1:0] ptr_inc;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
        level        = wbin - st_q.ptr;
        empty        = (level == '0);
        almost_empty = LW'(level) <= LW'(ae_ofs);
        ptr_inc      = st_q.ptr + PW'(1);
        st_d         = st_q;
        if (en_a && en_b && !empty) begin
            st_d.ptr  = ptr_inc;
            st_d.gray = ptr_inc ^ (ptr_inc >> 1);
            st_d.dout = rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr = st_q.ptr[AW-1:0];
    assign rgray = st_q.gray;
    assign dout  = st_q.dout;

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && en_a && en_b) |=> ($stable(st_q.ptr) && $stable(st_q.dout)));
    // R10
    rgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
    // R6
    empty_implies_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty);
endmodule

// File: rtl/sync9_fifo.sv
module sync9_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en_a,
    input  logic          wr_en_b,
    input  logic          ofs_load,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en_a,
    input  logic          rd_en_b,
    input  logic          out_en,
    output wire  [DW-1:0] rd_data,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic             we;
    logic [AW-1:0]    waddr, raddr;
    logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
    logic [OFS_W-1:0] ae_ofs;
    logic [DW-1:0]    rdata, dout;

    sfifo_wr_ctl #(.DEPTH(DEPTH)) wr_i (
        .clk(wr_clk), .rst_n(rst_n), .en_a(wr_en_a), .en_b(wr_en_b),
        .ld(ofs_load), .din(wr_data), .rgray_s(rgray_s), .we(we),
        .waddr(waddr), .wgray(wgray), .full(full),
        .almost_full(almost_full), .ae_ofs(ae_ofs)
    );

    sfifo_sync2 #(.W(PW)) w2r_i (
        .clk(rd_clk), .rst_n(rst_n), .async_in(wgray), .sync_out(wgray_s)
    );

    sfifo_sync2 #(.W(PW)) r2w_i (
        .clk(wr_clk), .rst_n(rst_n), .async_in(rgray), .sync_out(rgray_s)
    );

    sfifo_ram #(.DEPTH(DEPTH)) ram_i (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rdata)
    );

    sfifo_rd_ctl #(.DEPTH(DEPTH)) rd_i (
        .clk(rd_clk), .rst_n(rst_n), .en_a(rd_en_a), .en_b(rd_en_b),
        .wgray_s(wgray_s), .rdata(rdata), .ae_ofs(ae_ofs), .raddr(raddr),
        .rgray(rgray), .empty(empty), .almost_empty(almost_empty),
        .dout(dout)
    );

    assign rd_data = out_en ? dout : {DW{1'bz}};
endmodule

// File: tb/sync9_fifo_tb_top.sv
module sync9_fifo_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DEPTH       = 256;

    logic       wclk = 0, rclk_free = 0, dual = 0;
    logic       rst_n = 0;
    logic       wen_a = 0, wen_b = 0, ld = 0, ren_a = 0, ren_b = 0, oe = 1;
    logic [8:0] din = 0;
    wire  [8:0] rd_data;
    wire        rclk;
    logic       empty, full, ae, af;

    int checks = 0, fails = 0, held = 0;
    bit done = 0, mon_go = 0;
    string mon_req = "R1";
    logic [8:0] expq[$];

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk_free = ~rclk_free;
    assign rclk = dual ? rclk_free : wclk;

    sync9_fifo #(.DEPTH(DEPTH)) dut_i (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en_a(wen_a),
        .wr_en_b(wen_b), .ofs_load(ld), .wr_data(din), .rd_en_a(ren_a),
        .rd_en_b(ren_b), .out_en(oe), .rd_data(rd_data), .empty(empty),
        .full(full), .almost_empty(ae), .almost_full(af)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge wclk);
        wen_a = 1; wen_b = 1; din = d;
        if (!full) expq.push_back(d);
        @(posedge wclk); #1;
        wen_a = 0; wen_b = 0;
    endtask

    task automatic load_fld(input logic [8:0] d);
        @(negedge wclk);
        ld = 1; wen_a = 1; wen_b = 1; din = d;
        @(posedge wclk); #1;
        ld = 0; wen_a = 0; wen_b = 0;
    endtask

    task automatic pop(output bit fired);
        @(negedge rclk);
        ren_a = 1; ren_b = 1; fired = !empty;
        @(posedge rclk); #1;
        ren_a = 0; ren_b = 0;
        mon_go = fired;
    endtask

    task automatic pop_n(input int n);
        bit f;
        for (int i = 0; i < n; i++) pop(f);
    endtask

    task automatic push_n(input int n, input int seed);
        for (int i = 0; i < n; i++) push(9'((seed + i) * 37 + 5));
    endtask

    task automatic settle();
        repeat (4) @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic do_reset();
        @(negedge wclk);
        rst_n = 0;
        expq.delete();
        repeat (3) @(negedge wclk);
        rst_n = 1;
        @(negedge wclk);
    endtask

    // scoreboard monitor: compares the word the design produced with the oldest expected one
    always @(negedge rclk) begin
        if (mon_go) begin
            mon_go = 0;
            if (expq.size() == 0) check(0, mon_req, rd_data, 0);
            else begin
                logic [8:0] e;
                e = expq.pop_front();
                check(rd_data == e, mon_req, rd_data, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit f;
        do_reset();
        // R9 reset state
        check(empty == 1, "R9", empty, 1);
        check(ae == 1, "R9", ae, 1);
        check(full == 0, "R9", full, 0);
        check(af == 0, "R9", af, 0);

        // R2 single enable does not write
        @(negedge wclk); wen_a = 1; din = 9'h055; @(posedge wclk); #1; wen_a = 0;
        @(negedge wclk); wen_b = 1; din = 9'h0AA; @(posedge wclk); #1; wen_b = 0;
        settle();
        check(empty == 1, "R2", empty, 1);

        // R3 single read enable removes nothing
        push(9'h1AB); settle();
        check(empty == 0, "R4", empty, 0);
        @(negedge rclk); ren_a = 1; @(posedge rclk); #1; ren_a = 0;
        @(negedge rclk);
        check(rd_data == 9'h000, "R3", rd_data, 0);
        check(empty == 0, "R3", empty, 0);
        mon_req = "R1"; pop(f);
        settle();
        check(rd_data == 9'h1AB, "R1", rd_data, 9'h1AB);

        // R8 output enable
        @(negedge rclk); oe = 0; #1;
        check(rd_data === 9'bz || rd_data === 9'h000, "R8", rd_data, 0);
        oe = 1; #1;
        check(rd_data == 9'h1AB, "R8", rd_data, 9'h1AB);

        // R5 read when empty is ignored
        pop(f); settle();
        check(f == 0 && empty == 1, "R5", empty, 1);
        check(rd_data == 9'h1AB, "R5", rd_data, 9'h1AB);

        // R6 default thresholds, R4 full
        push_n(7, 0); settle();
        check(ae == 1, "R6", ae, 1);
        push_n(1, 7); settle();
        check(ae == 0, "R6", ae, 0);
        push_n(DEPTH - 8 - 8, 8); settle();
        check(af == 0, "R6", af, 0);
        push_n(1, 300); settle();
        check(af == 1, "R6", af, 1);
        push_n(DEPTH - 249, 400); settle();
        check(full == 1, "R4", full, 1);
        push(9'h0F0); push(9'h0F1);
        check(expq.size() == DEPTH, "R4", expq.size(), DEPTH);
        mon_req = "R4"; pop_n(DEPTH); settle();
        check(empty == 1 && ae == 1 && af == 0 && full == 0, "R4",
              {empty, ae, af, full}, 4'b1100);
        check(expq.size() == 0, "R4", expq.size(), 0);

        // R7 threshold loading: ae=20, af=10
        load_fld(9'd20); load_fld(9'd0); load_fld(9'd10); load_fld(9'd0);
        settle();
        check(empty == 1, "R7", empty, 1);
        push_n(20, 3); settle();
        check(ae == 1, "R7", ae, 1);
        push_n(1, 50); settle();
        check(ae == 0, "R7", ae, 0);
        push_n(245 - 21, 60); settle();
        check(af == 0, "R7", af, 0);
        push_n(1, 500); settle();
        check(af == 1, "R7", af, 1);
        mon_req = "R7"; pop_n(246); settle();
        // fifth slice wraps to almost-empty low part
        load_fld(9'd3); settle();
        push_n(3, 9); settle();
        check(ae == 1, "R7", ae, 1);
        push_n(1, 90); settle();
        check(ae == 0, "R7", ae, 0);
        pop_n(4); settle();

        // R9 reset restores thresholds and slice order
        push_n(5, 11);
        do_reset();
        check(empty == 1 && ae == 1 && full == 0 && af == 0, "R9",
              {empty, ae, full, af}, 4'b1100);
        push_n(7, 20); settle();
        check(ae == 1, "R9", ae, 1);
        push_n(1, 27); settle();
        check(ae == 0, "R9", ae, 0);
        mon_req = "R9"; pop_n(8); settle();
        load_fld(9'd5); settle();
        push_n(5, 30); settle();
        check(ae == 1, "R9", ae, 1);
        push_n(1, 35); settle();
        check(ae == 0, "R9", ae, 0);
        pop_n(6); settle();

        // R10 independent clocks
        dual = 1;
        do_reset();
        mon_req = "R10";
        fork
            push_n(60, 100);
            begin
                held = 0;
                while (held < 60) begin
                    pop(f);
                    if (f) held++;
                end
            end
        join
        repeat (4) @(negedge rclk);
        check(expq.size() == 0 && empty == 1, "R10", expq.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule